// File: doc/BRIEF.md
# Game Pad Poll Report Formatter

This block turns the latest 16-bit button word from a hand-held pad into the 64-bit reply that a console bus responder sends back on a poll. Each button is placed at its slot in the console's layout. The analog stick and trigger bytes carry fixed rest values, so every bit of the reply is always defined. The pad can be a 16-bit pad or an 8-bit pad. A mode input selects which one, and in 8-bit mode the buttons that such a pad does not have are masked off.

The block also watches for held button chords. One chord pushes the secondary (C) stick to one side. The other reports only the two shoulder buttons. Once a chord has fired, that override stays in force across samples, whatever else is pressed, until a sample arrives in which no button of the current mode is down. That sample returns the block to plain reporting. The button word and mode are taken only on a clock edge where the sample strobe is high. The report changes on those edges and on reset, and at no other time.

Top module: `report_formatter`

## Requirements
- R1: Button word bits are active high: 15 B, 14 Y, 13 Select, 12 Start, 11 Up, 10 Down, 9 Left, 8 Right, 7 A, 6 X, 5 L, 4 R; bits 3..0 are ignored. In plain reporting, report[63:56] = {0,0,0,Start,Y,X,B,A} and report[55:48] = {1,L,R,Select,Up,Down,Right,Left}.
- R2: report[47:40], report[39:32] and report[23:16] are always 0x80, and report[15:0] is always 0. report[31:24] (the C-stick horizontal byte) is 0x81 unless the deflection override is active.
- R3: In 16-bit mode (narrow_pad=0), a sample with L, R, Select and Left all pressed enters the deflection override: report[31:24]=0x01 and report[63:48]=0x0080.
- R4: In 8-bit mode (narrow_pad=1), a sample with A, B, Select and Left all pressed enters the deflection override, with the same report as in R3.
- R5: In 8-bit mode, a sample with A, B, Select and Up pressed, and Left not pressed, enters the shoulder-only override: report[63:48]=0x00E0 and report[31:24]=0x81. If Left and Up are both pressed with A, B and Select, the deflection override wins.
- R6: An active override keeps its report on every later sample, including samples where the other chord is pressed. The first sample in which no button of the current mode is pressed returns the block to plain reporting, and that sample's report is already a plain one.
- R7: In 8-bit mode, bits 14, 6, 5 and 4 (Y, X, L, R) are treated as released.
- R8: The report changes only on a rising clock edge with sample high. After reset it is 64'h0080_8080_8180_0000.
- R9: A chord has effect only in its own mode. The 8-bit chords do nothing in 16-bit mode, and the 16-bit chord cannot fire in 8-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_word | input | 16 | Button word, active-high bits as listed in R1 |
| sample | input | 1 | Strobe: take btn_word and narrow_pad on this edge |
| narrow_pad | input | 1 | 1 = 8-bit pad, 0 = 16-bit pad |
| report | output | 64 | Poll reply, byte 0 in bits 63..56, MSB first |

## Verification
Two things can land on the same sample: two chords that match at once, and a chord that matches while an override is already active. The bench provokes the first by pressing Left and Up together with A, B and Select, and expects the deflection report. It provokes the second by pressing the deflection chord during the shoulder-only override and by pressing extra buttons during deflection, and expects the held override's report each time. Release is checked in the same way: the same sample must both leave the override and show a plain report, including a sample whose only set bits are ones that the current mode masks off.

// File: rtl/rptfmt_pkg.sv
package rptfmt_pkg;
  localparam int BTN_W     = 16;
  localparam int IDX0      = 4;
  localparam int KEEP_W    = BTN_W - IDX0;
  localparam int RPT_BYTES = 8;
  localparam int RPT_W     = 8 * RPT_BYTES;

  // Positions in the incoming button word
  localparam int BI_B     = 15;
  localparam int BI_Y     = 14;
  localparam int BI_SEL   = 13;
  localparam int BI_START = 12;
  localparam int BI_UP    = 11;
  localparam int BI_DN    = 10;
  localparam int BI_LT    = 9;
  localparam int BI_RT    = 8;
  localparam int BI_A     = 7;
  localparam int BI_X     = 6;
  localparam int BI_L     = 5;
  localparam int BI_R     = 4;

  localparam logic [BTN_W-1:0] MASK_WIDE   = 16'hFFF0;
  localparam logic [BTN_W-1:0] MASK_NARROW = 16'hBF80;

  typedef enum logic [1:0] {
    OVR_NORMAL  = 2'd0,
    OVR_CSTICK  = 2'd1,
    OVR_LR_ONLY = 2'd2
  } ovr_e;

  function automatic logic [BTN_W-1:0] pad_mask(input logic [BTN_W-1:0] w,
                                                input logic narrow);
    return w & (narrow ? MASK_NARROW : MASK_WIDE);
  endfunction

  // First two reply bytes from the kept (upper) part of the word
  function automatic logic [15:0] digital_bytes(input logic [KEEP_W-1:0] k);
    return {3'b000, k[BI_START-IDX0], k[BI_Y-IDX0], k[BI_X-IDX0],
            k[BI_B-IDX0], k[BI_A-IDX0],
            1'b1, k[BI_L-IDX0], k[BI_R-IDX0], k[BI_SEL-IDX0],
            k[BI_UP-IDX0], k[BI_DN-IDX0], k[BI_RT-IDX0], k[BI_LT-IDX0]};
  endfunction
endpackage

// File: rtl/rptfmt_combo.sv
module rptfmt_combo
  import rptfmt_pkg::*;
(
  input  logic [BTN_W-1:0] btn,
  input  logic             narrow,
  output logic             hit_cstick,
  output logic             hit_lr,
  output logic             all_released
);
  logic sel, lt, up, a, b, l, r;

  always_comb begin
    sel = btn[BI_SEL];
    lt  = btn[BI_LT];
    up  = btn[BI_UP];
    a   = btn[BI_A];
    b   = btn[BI_B];
    l   = btn[BI_L];
    r   = btn[BI_R];
    hit_cstick   = sel & lt & (narrow ? (a & b) : (l & r));
    hit_lr       = narrow & a & b & sel & up;
    all_released = (btn == '0);
  end
endmodule

// File: rtl/rptfmt_fsm.sv
module rptfmt_fsm
  import rptfmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic hit_cstick,
  input  logic hit_lr,
  input  logic all_released,
  output ovr_e state
);
  ovr_e nxt;

  always_comb begin
    nxt = state;
    if (sample) begin
      unique case (state)
        OVR_NORMAL: begin
          if (hit_cstick)  nxt = OVR_CSTICK;
          else if (hit_lr) nxt = OVR_LR_ONLY;
        end
        default: if (all_released) nxt = OVR_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= OVR_NORMAL;
    else        state <= nxt;
  end
endmodule

// File: rtl/rptfmt_pack.sv
module rptfmt_pack
  import rptfmt_pkg::*;
#(
  parameter logic [7:0] STICK_REST    = 8'h80,
  parameter logic [7:0] CSTICK_CENTRE = 8'h81,
  parameter logic [7:0] CSTICK_DEFL   = 8'h01,
  parameter logic [7:0] TRIG_REST     = 8'h00
) (
  input  ovr_e              state,
  input  logic [KEEP_W-1:0] kept,
  output logic [RPT_W-1:0]  report
);
  logic [7:0]  rb [RPT_BYTES];
  logic [15:0] dig;

  always_comb begin
    unique case (state)
      OVR_CSTICK:  dig = digital_bytes('0);
      OVR_LR_ONLY: dig = digital_bytes(KEEP_W'((1 << (BI_L-IDX0)) | (1 << (BI_R-IDX0))));
      default:     dig = digital_bytes(kept);
    endcase
    rb[0] = dig[15:8];
    rb[1] = dig[7:0];
    rb[2] = STICK_REST;
    rb[3] = STICK_REST;
    rb[4] = (state == OVR_CSTICK) ? CSTICK_DEFL : CSTICK_CENTRE;
    rb[5] = STICK_REST;
    rb[6] = TRIG_REST;
    rb[7] = TRIG_REST;
  end

  for (genvar i = 0; i < RPT_BYTES; i++) begin : g_place
    assign report[RPT_W-1-8*i -: 8] = rb[i];
  end
endmodule

// File: rtl/report_formatter.sv
module report_formatter
  import rptfmt_pkg::*;
#(
  parameter logic [7:0] STICK_REST    = 8'h80,
  parameter logic [7:0] CSTICK_CENTRE = 8'h81,
  parameter logic [7:0] CSTICK_DEFL   = 8'h01,
  parameter logic [7:0] TRIG_REST     = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] btn_word,
  input  logic        sample,
  input  logic        narrow_pad,
  output logic [63:0] report
);
  logic [BTN_W-1:0]  masked;
  logic [KEEP_W-1:0] kept_q;
  logic              hit_cstick, hit_lr, all_released;
  ovr_e              ovr_state;

  assign masked = pad_mask(btn_word, narrow_pad);

  rptfmt_combo u_combo (
    .btn          (masked),
    .narrow       (narrow_pad),
    .hit_cstick   (hit_cstick),
    .hit_lr       (hit_lr),
    .all_released (all_released)
  );

  rptfmt_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample       (sample),
    .hit_cstick   (hit_cstick),
    .hit_lr       (hit_lr),
    .all_released (all_released),
    .state        (ovr_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      kept_q <= '0;
    else if (sample) kept_q <= masked[BTN_W-1:IDX0];
  end

  rptfmt_pack #(
    .STICK_REST    (STICK_REST),
    .CSTICK_CENTRE (CSTICK_CENTRE),
    .CSTICK_DEFL   (CSTICK_DEFL),
    .TRIG_REST     (TRIG_REST)
  ) u_pack (
    .state  (ovr_state),
    .kept   (kept_q),
    .report (report)
  );
endmodule

// File: rtl/rptfmt_checker.sv
module rptfmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sample,
  input logic [63:0] report,
  input logic [1:0]  ovr_state,
  input logic        hit_cstick,
  input logic        hit_lr,
  input logic        all_released
);
  p_frame_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    report[63:61] == 3'b000 && report[55]);

  p_fixed_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    report[47:32] == 16'h8080 && report[23:0] == 24'h800000);

  // R3 and R4: entering deflection
  p_cstick_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && ovr_state == 2'd0 && hit_cstick)
    |=> (report[31:24] == 8'h01 && report[63:48] == 16'h0080));

  p_lr_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && ovr_state == 2'd0 && !hit_cstick && hit_lr)
    |=> (report[63:48] == 16'h00E0 && report[31:24] == 8'h81));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_state != 2'd0 && !(sample && all_released))
    |=> ovr_state == $past(ovr_state));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && all_released) |=> (ovr_state == 2'd0 && report[63:48] == 16'h0080));

  p_sample_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(report));
endmodule

bind report_formatter rptfmt_checker u_rptfmt_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample       (sample),
  .report       (report),
  .ovr_state    (ovr_state),
  .hit_cstick   (hit_cstick),
  .hit_lr       (hit_lr),
  .all_released (all_released)
);

// File: tb/tb_report_formatter.sv
`timescale 1ns/1ps
module tb_report_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] btn_word = '0;
  logic        sample = 1'b0;
  logic        narrow_pad = 1'b0;
  logic [63:0] report;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] RESET_VAL = 64'h0080_8080_8180_0000;

  // {narrow, word, expected report[63:48], expected C byte}
  localparam int NV = 24;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 16'h0000, 16'h0080, 8'h81},  // R1 idle
    {1'b0, 16'h1000, 16'h1080, 8'h81},  // R1 start
    {1'b0, 16'h8080, 16'h0380, 8'h81},  // R1 B A
    {1'b0, 16'h4040, 16'h0C80, 8'h81},  // R1 Y X
    {1'b0, 16'h0030, 16'h00E0, 8'h81},  // R1 L R
    {1'b0, 16'h2900, 16'h009A, 8'h81},  // R1 sel up right
    {1'b0, 16'h0600, 16'h0085, 8'h81},  // R1 down left
    {1'b0, 16'h000F, 16'h0080, 8'h81},  // R1 low bits ignored
    {1'b1, 16'h407F, 16'h0080, 8'h81},  // R7 narrow masks Y X L R
    {1'b0, 16'hA880, 16'h0398, 8'h81},  // R9 narrow chord in wide mode
    {1'b1, 16'h2230, 16'h0091, 8'h81},  // R9 wide chord in narrow mode
    {1'b0, 16'h2230, 16'h0080, 8'h01},  // R3 wide deflection
    {1'b0, 16'h2200, 16'h0080, 8'h01},  // R6 hold partial
    {1'b0, 16'hFFF0, 16'h0080, 8'h01},  // R6 hold all pressed
    {1'b0, 16'h000F, 16'h0080, 8'h81},  // R6 release via masked bits
    {1'b1, 16'hA280, 16'h0080, 8'h01},  // R4 narrow deflection
    {1'b1, 16'h4070, 16'h0080, 8'h81},  // R7 release, only masked bits
    {1'b1, 16'hA880, 16'h00E0, 8'h81},  // R5 shoulder only
    {1'b1, 16'h8000, 16'h00E0, 8'h81},  // R6 hold
    {1'b1, 16'hA280, 16'h00E0, 8'h81},  // R6 other chord ignored
    {1'b1, 16'h0000, 16'h0080, 8'h81},  // R6 release
    {1'b1, 16'hAA80, 16'h0080, 8'h01},  // R5 left beats up
    {1'b1, 16'h0000, 16'h0080, 8'h81},  // R6 release
    {1'b1, 16'h1F80, 16'h118F, 8'h81}   // R1 narrow plain
  };

  report_formatter dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .btn_word   (btn_word),
    .sample     (sample),
    .narrow_pad (narrow_pad),
    .report     (report)
  );

  always #2.5 clk = ~clk;

  function automatic logic [63:0] full_report(input logic [15:0] hi, input logic [7:0] c);
    return {hi, 8'h80, 8'h80, c, 8'h80, 16'h0000};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic nar, input logic [15:0] w);
    @(negedge clk);
    narrow_pad = nar;
    btn_word   = w;
    sample     = 1'b1;
    @(negedge clk);
    sample     = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R8 value during reset", report, RESET_VAL);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 value after reset", report, RESET_VAL);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][40], VEC[i][39:24]);
      check($sformatf("R1/R2 vector %0d", i), report,
            full_report(VEC[i][23:8], VEC[i][7:0]));
    end

    // R8: no strobe, report holds whatever the inputs do
    held = report;
    @(negedge clk);
    btn_word   = 16'h2230;
    narrow_pad = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 no strobe hold", report, held);

    // R8: reset in the middle of an override
    step(1'b0, 16'h2230);
    check("R3 deflection before reset", report, full_report(16'h0080, 8'h01));
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset clears override", report, RESET_VAL);
    rst_n = 1'b1;
    step(1'b0, 16'h0030);
    check("R6 plain after reset", report, full_report(16'h00E0, 8'h81));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule